// File: doc/BRIEF.md
# Manchester Serial Word Receiver

This block turns the two comparator outputs of a differential bus receiver into checked 16-bit words. The positive comparator (`rx_p`) alone active means the line is high. The negative comparator (`rx_n`) alone active means it is low. Neither or both active means no signal.

The block waits for the line to leave the quiet state. It then follows a three-bit-time sync waveform, seventeen Manchester cells and the end of the word on one fixed grid of sample points. Each point lies a quarter bit from the edges of its half-bit.

A word is a sync, then 16 data bits sent MSB first, then one odd-parity bit, at 1 Mbit/s. Every word ends in a one-cycle strobe. `word_valid` carries the data and the sync type. `word_err` carries a cause code.

The sampling mode is selected by `mode_dual`:
- When it is low, one sample is taken per clock on the rising edge, 16 samples per bit (16 MHz clock).
- When it is high, a second sample is also captured on the falling edge, 24 samples per bit from a 12 MHz clock.

After any error the receiver waits for a quiet line. It then accepts the next sync.

Top module: `manchester_word_rx`

## Requirements
- R1: After reset `word_valid` and `word_err` are low and `word_data`, `word_cmd` and `err_code` are zero.
- R2: A command/status sync (line high 1.5 bit times, then low 1.5 bit times), 16 valid Manchester bits sent MSB first (a one is high then low) and a correct odd parity bit give exactly one one-cycle `word_valid` pulse. In that pulse `word_data` holds the 16 bits, `word_cmd`=1 and `err_code`=0, and `word_valid` and `word_err` are never high together.
- R3: A data sync (low 1.5 bit times, then high 1.5 bit times) gives `word_cmd`=0 with the word's data.
- R4: With `mode_dual`=0 the receiver decodes at 16 samples per bit from rising edges only. With `mode_dual`=1 it decodes at 24 samples per bit taken on both clock edges.
- R5: A sync whose level is wrong or missing at any of its five check points (0.75, 1.25, 1.75, 2.25, 2.75 bit times) gives one `word_err` pulse with `err_code`=1.
- R6: When `type_chk_en`=1 and the sync type differs from `type_exp` (1 = command/status), an otherwise correct sync gives `err_code`=2.
- R7: A data cell whose two halves carry the same level gives `err_code`=3.
- R8: A word whose 16 data bits plus parity bit hold an even number of ones gives `err_code`=4.
- R9: The word gives `err_code`=5 in either of two cases: the line is quiet at a check point inside the 17 cells (short word), or the line is still driven a quarter bit after the parity cell (long word). The long-word cause overrides a parity error in the same word, and neither case stalls the receiver.
- R10: After any error the receiver decodes the next correct word, once the line has been quiet, with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 MHz single-edge or 12 MHz dual-edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dual | input | 1 | 1 = sample on both edges (24 samples/bit), 0 = rising edge only (16 samples/bit) |
| rx_p | input | 1 | Positive comparator output, line high |
| rx_n | input | 1 | Negative comparator output, line low |
| type_chk_en | input | 1 | Enable the expected-sync-type check |
| type_exp | input | 1 | Expected sync type, 1 = command/status |
| word_valid | output | 1 | One-cycle strobe for a correct word |
| word_err | output | 1 | One-cycle strobe for a rejected word |
| err_code | output | 3 | Error cause: 1 sync, 2 type, 3 Manchester, 4 parity, 5 bit count, 0 after a good word |
| word_data | output | 16 | Last correct word's data |
| word_cmd | output | 1 | Sync type of the last correct word, 1 = command/status |

## Verification
Two judgements can fall in the same cycle:
- At the final check point, a quarter bit after the parity cell, the long-word test and the parity test both look at the word. The bench provokes this with a word that has a flipped parity bit and one extra Manchester cell. It passes only if a single error pulse carries the bit-count cause and not the parity cause.
- At the last sync check point, the waveform test and the expected-type test coincide. A well-formed sync of the wrong type must yield the type cause, and the same sync with the check disabled must decode cleanly.

// File: rtl/manchester_word_rx.sv
module manchester_word_rx #(
  parameter int SPB_ONE = 16,
  parameter int SPB_TWO = 24,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_dual,
  input  logic          rx_p,
  input  logic          rx_n,
  input  logic          type_chk_en,
  input  logic          type_exp,
  output logic          word_valid,
  output logic          word_err,
  output logic [2:0]    err_code,
  output logic [DW-1:0] word_data,
  output logic          word_cmd
);
  localparam int LAST    = 2*DW + 7;
  localparam int CW      = $clog2(LAST + 1);
  localparam int SPB_MAX = (SPB_TWO > SPB_ONE) ? SPB_TWO : SPB_ONE;
  localparam int PW      = $clog2(SPB_MAX*(DW + 5)) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HUNT} st_t;

  st_t           state;
  logic [1:0]    s_a;
  logic [PW-1:0] pos, tgt, qtr;
  logic [CW-1:0] chk;
  logic          pol, h0;
  logic [DW:0]   sh;
  logic [2:0]    ecode;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) s_a <= 2'b00;
    else        s_a <= {rx_p, rx_n};

  assign qtr = mode_dual ? PW'(SPB_TWO/4) : PW'(SPB_ONE/4);
  assign tgt = qtr * (PW'(3) + (PW'(chk) << 1));

  wire       hit_b = (pos == tgt);
  wire       hit_a = mode_dual && (pos == tgt + PW'(1));
  wire       hit   = hit_a || hit_b;
  wire [1:0] smp   = hit_a ? s_a : {rx_p, rx_n};
  wire       act   = smp[1] ^ smp[0];
  wire       lvl   = smp[1];
  wire       a_act = mode_dual && (s_a[1] ^ s_a[0]);
  wire       b_act = rx_p ^ rx_n;
  wire       quiet = !b_act && !a_act;

  always_comb begin
    ecode = 3'd0;
    if (state == S_RUN && hit) begin
      if (chk < CW'(2)) begin
        if (!act || lvl != pol) ecode = 3'd1;
      end else if (chk < CW'(5)) begin
        if (!act || lvl == pol) ecode = 3'd1;
        else if (chk == CW'(4) && type_chk_en && pol != type_exp) ecode = 3'd2;
      end else if (chk == CW'(LAST)) begin
        if (act)      ecode = 3'd5;
        else if (!(^sh)) ecode = 3'd4;
      end else begin
        if (!act)                    ecode = 3'd5;
        else if (!chk[0] && lvl == h0) ecode = 3'd3;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pos        <= '0;
      chk        <= '0;
      pol        <= 1'b0;
      h0         <= 1'b0;
      sh         <= '0;
      word_valid <= 1'b0;
      word_err   <= 1'b0;
      err_code   <= 3'd0;
      word_data  <= '0;
      word_cmd   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      word_err   <= 1'b0;
      case (state)
        S_IDLE: begin
          chk <= '0;
          if (a_act) begin
            pol <= s_a[1]; pos <= PW'(1); state <= S_RUN;
          end else if (b_act) begin
            pol <= rx_p;   pos <= '0;     state <= S_RUN;
          end
        end
        S_RUN: begin
          pos <= pos + (mode_dual ? PW'(2) : PW'(1));
          if (hit) begin
            if (ecode != 3'd0) begin
              word_err <= 1'b1;
              err_code <= ecode;
              state    <= S_HUNT;
            end else if (chk == CW'(LAST)) begin
              word_valid <= 1'b1;
              err_code   <= 3'd0;
              word_data  <= sh[DW:1];
              word_cmd   <= pol;
              state      <= S_IDLE;
            end else begin
              chk <= chk + CW'(1);
              if (chk >= CW'(5)) begin
                if (chk[0]) h0 <= lvl;
                else        sh <= {sh[DW-1:0], h0};
              end
            end
          end
        end
        default: if (quiet) state <= S_IDLE;
      endcase
    end
  end

  assert_excl_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && word_err));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid && !word_err);
  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |-> (err_code != 3'd0 && err_code <= 3'd5));
  assert_err_hunts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |-> state == S_HUNT);
  assert_chk_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> chk <= CW'(LAST));
endmodule

// File: tb/manchester_word_rx_tb_top.sv
`timescale 1ns/1ps
module manchester_word_rx_tb_top;
  logic clk = 0, rst_n = 0, mode_dual = 0, rx_p = 0, rx_n = 0;
  logic type_chk_en = 0, type_exp = 0;
  logic word_valid, word_err, word_cmd;
  logic [2:0] err_code;
  logic [15:0] word_data;

  int checks = 0, fails = 0;
  int n_ok = 0, n_bad = 0;
  logic [15:0] got_data;
  logic got_cmd;
  logic [2:0] got_code;
  logic [1:0] hv [0:63];
  int nh;

  always #4 clk = ~clk;

  manchester_word_rx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual), .rx_p(rx_p), .rx_n(rx_n),
    .type_chk_en(type_chk_en), .type_exp(type_exp), .word_valid(word_valid),
    .word_err(word_err), .err_code(err_code), .word_data(word_data), .word_cmd(word_cmd));

  always @(negedge clk) begin
    if (word_valid) begin n_ok++; got_data = word_data; got_cmd = word_cmd; end
    if (word_err) begin n_bad++; got_code = err_code; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic l);
    hv[nh] = {l, ~l}; nh++;
  endtask

  task automatic build(input logic cmd, input logic [15:0] d, input bit flip_par,
                       input int extra, input int cut, input int bad_bit, input bit bad_sync);
    logic par, b;
    nh = 0;
    par = ~(^d) ^ flip_par;
    push(cmd); push(cmd); push(bad_sync ? ~cmd : cmd);
    push(~cmd); push(~cmd); push(~cmd);
    for (int i = 0; i < 17; i++) begin
      if (i == cut) break;
      b = (i < 16) ? d[15-i] : par;
      push(b); push(i == bad_bit ? b : ~b);
    end
    for (int e = 0; e < extra; e++) begin push(1'b1); push(1'b0); end
    for (int k = 0; k < 4; k++) begin hv[nh] = 2'b00; nh++; end
  endtask

  task automatic play();
    int slot = mode_dual ? 4 : 8;
    int per  = (mode_dual ? 24 : 16) / 2;
    n_ok = 0; n_bad = 0;
    @(posedge clk); #2;
    for (int h = 0; h < nh; h++)
      for (int s = 0; s < per; s++) begin {rx_p, rx_n} = hv[h]; #(slot); end
    {rx_p, rx_n} = 2'b00;
    repeat (10) @(posedge clk);
  endtask

  task automatic expect_ok(input string tag, input logic cmd, input logic [15:0] d);
    check(n_ok == 1, {tag, " valid count"}, n_ok, 1);
    check(n_bad == 0, {tag, " error count"}, n_bad, 0);
    if (n_ok == 1) begin
      check(got_data == d, {tag, " data"}, got_data, d);
      check(got_cmd == cmd, {tag, " sync type"}, got_cmd, cmd);
    end
  endtask

  task automatic expect_err(input string tag, input logic [2:0] code);
    check(n_bad == 1, {tag, " error count"}, n_bad, 1);
    check(n_ok == 0, {tag, " valid count"}, n_ok, 0);
    if (n_bad == 1) check(got_code == code, {tag, " cause"}, got_code, code);
  endtask

  task automatic t_reset();
    check(!word_valid && !word_err, "R1 strobes", {word_valid, word_err}, 0);
    check(word_data == 0 && err_code == 0 && !word_cmd, "R1 outputs",
          {word_data, err_code, word_cmd}, 0);
  endtask

  task automatic t_cmd_single();
    mode_dual = 0;
    build(1, 16'hA5C3, 0, 0, -1, -1, 0); play(); expect_ok("R2 cmd word", 1, 16'hA5C3);
  endtask

  task automatic t_data_single();
    mode_dual = 0;
    build(0, 16'h0001, 0, 0, -1, -1, 0); play(); expect_ok("R3 data word", 0, 16'h0001);
  endtask

  task automatic t_dual();
    mode_dual = 1;
    build(1, 16'h8000, 0, 0, -1, -1, 0); play(); expect_ok("R4 dual cmd", 1, 16'h8000);
    build(0, 16'hFFFF, 0, 0, -1, -1, 0); play(); expect_ok("R4 dual data", 0, 16'hFFFF);
    build(1, 16'h3C5A, 0, 0, -1, 12, 0); play(); expect_err("R4 R7 dual manchester", 3'd3);
    mode_dual = 0;
  endtask

  task automatic t_sync_err();
    build(1, 16'h1234, 0, 0, -1, -1, 1); play(); expect_err("R5 sync shape", 3'd1);
  endtask

  task automatic t_type();
    type_chk_en = 1; type_exp = 1;
    build(0, 16'h4321, 0, 0, -1, -1, 0); play(); expect_err("R6 wrong type", 3'd2);
    build(1, 16'h4321, 0, 0, -1, -1, 0); play(); expect_ok("R6 right type", 1, 16'h4321);
    type_chk_en = 0;
    build(0, 16'h4321, 0, 0, -1, -1, 0); play(); expect_ok("R6 check off", 0, 16'h4321);
  endtask

  task automatic t_manchester();
    build(0, 16'hBEEF, 0, 0, -1, 7, 0); play(); expect_err("R7 manchester", 3'd3);
  endtask

  task automatic t_parity();
    build(1, 16'h0F0F, 1, 0, -1, -1, 0); play(); expect_err("R8 parity", 3'd4);
  endtask

  task automatic t_count();
    build(1, 16'h5555, 0, 0, 10, -1, 0); play(); expect_err("R9 short", 3'd5);
    build(0, 16'h6666, 1, 1, -1, -1, 0); play(); expect_err("R9 long over parity", 3'd5);
  endtask

  task automatic t_resync();
    build(1, 16'h2222, 0, 0, 4, -1, 0); play(); expect_err("R10 bad first", 3'd5);
    build(1, 16'hC001, 0, 0, -1, -1, 0); play(); expect_ok("R10 recovers", 1, 16'hC001);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    rst_n = 1;
    repeat (3) @(posedge clk);
    t_cmd_single();
    t_data_single();
    t_dual();
    t_sync_err();
    t_type();
    t_manchester();
    t_parity();
    t_count();
    t_resync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule